// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block deserialises audio samples arriving on a single data line. It runs entirely on the incoming bit clock (rising-edge sampling) and works as a slave: the bit clock and the left/right framing clock both come from outside. Each completed word is delivered as a right-aligned parallel value together with a channel index and a one-cycle valid strobe.

Five framing formats can be selected at runtime. Three are two-channel formats: left-justified, I2S and right-justified, in which the framing clock is high for the left channel and low for the right. Two are multi-channel formats, DSP early and DSP late, in which a rising edge of the framing clock marks the start of a frame. In the DSP formats up to eight words follow back to back. The word length can be set to 16, 20, 24 or 32 bits. The block also checks that every half-period or frame lasts at least the required number of bit clocks, and raises a one-cycle error pulse when it does not.

Top module: `asr_rx`

## Requirements
- R1: With `fmt`=0 (left-justified), the MSB is sampled on the first rising `bclk` edge after any change of `lrclk`. The word is W bits long. Its channel is 0 when `lrclk` is high and 1 when it is low. Bits after the word, up to the next change, are ignored.
- R2: With `fmt`=2 (I2S), the capture is the same as in R1 but starts one `bclk` later: the MSB is taken on the second rising edge after the change.
- R3: With `fmt`=1 (right-justified), each change of `lrclk` delivers the last W bits sampled before the edge that sees the change. The channel is the one of the half that just ended. The first change after reset only establishes alignment and delivers nothing.
- R4: With `fmt`=3 (DSP early), the MSB of channel 0 is sampled on the edge that sees `lrclk` rise. Channels 1 to 7 follow back to back without gaps. The width and the falling edge of the sync pulse have no effect.
- R5: With `fmt`=4 (DSP late), the capture is the same as in R4 but starts one `bclk` later.
- R6: `wlen` codes 0, 1, 2 and 3 select W = 16, 20, 24 and 32. Data is right-aligned in `sample_data`, and all bits at or above W are zero.
- R7: `sample_valid` is high for exactly the one cycle after the edge that samples a word's LSB; in right-justified mode, after the edge that sees the change. `sample_data` and `sample_chan` change only together with the strobe.
- R8: In the two-channel formats, a half-period shorter than W `bclk` cycles raises `frame_err` for one cycle after the edge that sees the change ending it. The first change after reset is not checked.
- R9: In the DSP formats, a frame shorter than 8·W `bclk` cycles, measured from one sync rise to the next, raises `frame_err` in the same way.
- R10: A word cut short by a new frame boundary is dropped and produces no strobe.
- R11: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 3 | Framing format code (see R1–R5) |
| wlen | input | 2 | Word length code (see R6) |
| lrclk | input | 1 | Left/right clock or frame sync |
| sdata | input | 1 | Serial audio data |
| sample_valid | output | 1 | One-cycle strobe for a completed word |
| sample_data | output | MAX_W | Right-aligned sample |
| sample_chan | output | clog2(MAX_CH) | Channel index of the sample |
| frame_err | output | 1 | One-cycle framing-length error pulse |

## Verification
In right-justified mode, a short half-period makes the sample delivery and the framing error fall in the same cycle, because both are decided on the edge that sees the framing clock change. Every stereo stream in the sweep contains a half of W−3 bits. For that half the bench expects the strobe to carry the last W stream bits before the boundary and the error pulse to appear in the same sampled cycle. Both expectations are derived from the generated bit stream, never from the design.

// File: rtl/asr_pkg.sv
package asr_pkg;

    typedef enum logic [2:0] {
        FMT_LJ        = 3'd0,
        FMT_RJ        = 3'd1,
        FMT_I2S       = 3'd2,
        FMT_DSP_EARLY = 3'd3,
        FMT_DSP_LATE  = 3'd4
    } asr_fmt_e;

    function automatic logic asr_is_dsp(input logic [2:0] f);
        return (f == 3'd3) || (f == 3'd4);
    endfunction

    function automatic logic [5:0] asr_word_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 6'd16;
            2'd1:    return 6'd20;
            2'd2:    return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/asr_framer.sv
module asr_framer
    import asr_pkg::*;
#(
    parameter int MAX_W  = 32,
    parameter int MAX_CH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] fmt,
    input  logic [1:0] wlen,
    input  logic       lrclk,
    output logic       bnd,
    output logic       bnd_q,
    output logic       lrc_q,
    output logic       synced,
    output logic       frame_err
);
    localparam int CNT_W = $clog2(MAX_CH * MAX_W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             lrc;
        logic             armed;
        logic             synced;
        logic             bnd;
        logic             err;
        logic [CNT_W-1:0] per;
    } frm_t;

    frm_t             s_d, s_q;
    logic             dsp;
    logic             hit;
    logic [CNT_W-1:0] min_len;

    always_comb begin
        dsp     = asr_is_dsp(fmt);
        min_len = dsp ? CNT_W'(MAX_CH) * CNT_W'(asr_word_bits(wlen))
                      : CNT_W'(asr_word_bits(wlen));
        hit     = s_q.armed & (dsp ? (lrclk & ~s_q.lrc) : (lrclk ^ s_q.lrc));

        s_d        = s_q;
        s_d.lrc    = lrclk;
        s_d.armed  = 1'b1;
        s_d.bnd    = hit;
        s_d.synced = s_q.synced | hit;
        if (hit) begin
            s_d.per = CNT_W'(1);
        end else if (s_q.per != CNT_MAX) begin
            s_d.per = s_q.per + CNT_W'(1);
        end
        s_d.err = hit & s_q.synced & (s_q.per < min_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bnd       = hit;
    assign bnd_q     = s_q.bnd;
    assign lrc_q     = s_q.lrc;
    assign synced    = s_q.synced;
    assign frame_err = s_q.err;
endmodule

// File: rtl/asr_shifter.sv
module asr_shifter
    import asr_pkg::*;
#(
    parameter int MAX_W  = 32,
    parameter int MAX_CH = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2:0]                fmt,
    input  logic [1:0]                wlen,
    input  logic                      lrclk,
    input  logic                      sdata,
    input  logic                      bnd,
    input  logic                      bnd_q,
    input  logic                      lrc_q,
    input  logic                      synced,
    output logic                      valid,
    output logic [MAX_W-1:0]          data,
    output logic [$clog2(MAX_CH)-1:0] chan
);
    localparam int CH_W = $clog2(MAX_CH);
    localparam int BC_W = $clog2(MAX_W + 1);

    typedef struct packed {
        logic [MAX_W-1:0] sr;
        logic             active;
        logic [BC_W-1:0]  bcnt;
        logic [CH_W-1:0]  chan;
        logic             vld;
        logic [MAX_W-1:0] data;
        logic [CH_W-1:0]  ochan;
    } shf_t;

    shf_t             s_d, s_q;
    asr_fmt_e         fmt_e;
    logic             dsp;
    logic             start;
    logic [BC_W-1:0]  wb;
    logic [MAX_W-1:0] mask;
    logic [MAX_W-1:0] shifted;

    always_comb begin
        fmt_e   = asr_fmt_e'(fmt);
        dsp     = asr_is_dsp(fmt);
        wb      = BC_W'(asr_word_bits(wlen));
        mask    = ~({MAX_W{1'b1}} << wb);
        shifted = {s_q.sr[MAX_W-2:0], sdata};
        case (fmt_e)
            FMT_I2S, FMT_DSP_LATE: start = bnd_q;
            FMT_RJ:                start = 1'b0;
            default:               start = bnd;
        endcase

        s_d     = s_q;
        s_d.sr  = shifted;
        s_d.vld = 1'b0;
        if (fmt_e == FMT_RJ) begin
            s_d.active = 1'b0;
            if (bnd && synced) begin
                s_d.vld   = 1'b1;
                s_d.data  = s_q.sr & mask;
                s_d.ochan = lrc_q ? '0 : CH_W'(1);
            end
        end else if (start) begin
            s_d.active = 1'b1;
            s_d.bcnt   = BC_W'(1);
            s_d.chan   = (dsp || lrclk) ? '0 : CH_W'(1);
        end else if (s_q.active) begin
            s_d.bcnt = s_q.bcnt + BC_W'(1);
            if (s_q.bcnt == wb - BC_W'(1)) begin
                s_d.vld   = 1'b1;
                s_d.data  = shifted & mask;
                s_d.ochan = s_q.chan;
                if (dsp && s_q.chan != CH_W'(MAX_CH - 1)) begin
                    s_d.bcnt = '0;
                    s_d.chan = s_q.chan + CH_W'(1);
                end else begin
                    s_d.active = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid = s_q.vld;
    assign data  = s_q.data;
    assign chan  = s_q.ochan;
endmodule

// File: rtl/asr_rx.sv
module asr_rx #(
    parameter int MAX_W  = 32,
    parameter int MAX_CH = 8
) (
    input  logic                      bclk,
    input  logic                      rst_n,
    input  logic [2:0]                fmt,
    input  logic [1:0]                wlen,
    input  logic                      lrclk,
    input  logic                      sdata,
    output logic                      sample_valid,
    output logic [MAX_W-1:0]          sample_data,
    output logic [$clog2(MAX_CH)-1:0] sample_chan,
    output logic                      frame_err
);
    logic bnd, bnd_q, lrc_q, synced;

    asr_framer #(.MAX_W(MAX_W), .MAX_CH(MAX_CH)) u_framer (
        .clk       (bclk),
        .rst_n     (rst_n),
        .fmt       (fmt),
        .wlen      (wlen),
        .lrclk     (lrclk),
        .bnd       (bnd),
        .bnd_q     (bnd_q),
        .lrc_q     (lrc_q),
        .synced    (synced),
        .frame_err (frame_err)
    );

    asr_shifter #(.MAX_W(MAX_W), .MAX_CH(MAX_CH)) u_shifter (
        .clk    (bclk),
        .rst_n  (rst_n),
        .fmt    (fmt),
        .wlen   (wlen),
        .lrclk  (lrclk),
        .sdata  (sdata),
        .bnd    (bnd),
        .bnd_q  (bnd_q),
        .lrc_q  (lrc_q),
        .synced (synced),
        .valid  (sample_valid),
        .data   (sample_data),
        .chan   (sample_chan)
    );
endmodule

// File: rtl/asr_rx_chk.sv
module asr_rx_chk #(
    parameter int MAX_W  = 32,
    parameter int MAX_CH = 8
) (
    input logic                      bclk,
    input logic                      rst_n,
    input logic [2:0]                fmt,
    input logic [1:0]                wlen,
    input logic                      lrclk,
    input logic                      sample_valid,
    input logic [MAX_W-1:0]          sample_data,
    input logic [$clog2(MAX_CH)-1:0] sample_chan,
    input logic                      frame_err
);
    logic [MAX_W-1:0] hi_mask;
    logic             is_dsp;

    always_comb begin
        hi_mask = '1;
        for (int i = 0; i < MAX_W; i++) begin
            case (wlen)
                2'd0:    hi_mask[i] = (i >= 16);
                2'd1:    hi_mask[i] = (i >= 20);
                2'd2:    hi_mask[i] = (i >= 24);
                default: hi_mask[i] = (i >= 32);
            endcase
        end
        is_dsp = (fmt == 3'd3) || (fmt == 3'd4);
    end

    AST_SINGLE_STROBE: assert property (@(posedge bclk) disable iff (!rst_n)
        (sample_valid && fmt != 3'd1) |=> !sample_valid); // R7

    AST_HOLD_BETWEEN: assert property (@(posedge bclk) disable iff (!rst_n)
        !sample_valid |-> ($stable(sample_data) && $stable(sample_chan))); // R7

    AST_STEREO_CHAN: assert property (@(posedge bclk) disable iff (!rst_n)
        (sample_valid && fmt < 3'd3) |-> (sample_chan <= 1)); // R1

    AST_UPPER_ZERO: assert property (@(posedge bclk) disable iff (!rst_n)
        sample_valid |-> ((sample_data & hi_mask) == '0)); // R6

    AST_ERR_AT_EDGE: assert property (@(posedge bclk) disable iff (!rst_n)
        frame_err |-> (is_dsp ? ($past(lrclk) && !$past(lrclk, 2))
                              : ($past(lrclk) != $past(lrclk, 2)))); // R8

    AST_RJ_AT_EDGE: assert property (@(posedge bclk) disable iff (!rst_n)
        (sample_valid && fmt == 3'd1) |-> ($past(lrclk) != $past(lrclk, 2))); // R3
endmodule

bind asr_rx asr_rx_chk #(.MAX_W(MAX_W), .MAX_CH(MAX_CH)) u_chk (
    .bclk         (bclk),
    .rst_n        (rst_n),
    .fmt          (fmt),
    .wlen         (wlen),
    .lrclk        (lrclk),
    .sample_valid (sample_valid),
    .sample_data  (sample_data),
    .sample_chan  (sample_chan),
    .frame_err    (frame_err)
);

// File: tb/tb_asr_rx.sv
`timescale 1ns/1ps
module tb_asr_rx;
    localparam int MAXS = 1100;
    localparam int MAXE = 64;

    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fmt = '0;
    logic [1:0]  wlen = '0;
    logic        lrclk = 1'b0;
    logic        sdata = 1'b0;
    logic        sample_valid;
    logic [31:0] sample_data;
    logic [2:0]  sample_chan;
    logic        frame_err;

    asr_rx dut (
        .bclk(bclk), .rst_n(rst_n), .fmt(fmt), .wlen(wlen),
        .lrclk(lrclk), .sdata(sdata), .sample_valid(sample_valid),
        .sample_data(sample_data), .sample_chan(sample_chan), .frame_err(frame_err)
    );

    always #5 bclk = ~bclk;

    int checks = 0;
    int errors = 0;
    logic        lr_s [MAXS];
    logic        d_s  [MAXS];
    logic        e_s  [MAXS];
    int          n_s;
    logic [31:0] exp_d [MAXE];
    int          exp_c [MAXE];
    int          exp_k [MAXE];
    int          n_exp;
    int          got;

    function automatic int wbits(int wl);
        case (wl)
            0: return 16;
            1: return 20;
            2: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic string tag(int f);
        case (f)
            0: return "R1";
            1: return "R3";
            2: return "R2";
            3: return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic logic pad_bit(int k, int f, int wl);
        return ((k * 37 + f * 11 + wl * 5) % 7) < 3;
    endfunction

    function automatic logic [31:0] gen_word(int idx, int f, int wl, int w);
        logic [31:0] v;
        v = (32'(idx + 1) * 32'h9E3779B1) ^ 32'(f * 131 + wl * 17) ^ 32'h5A5AC3C3;
        if (w < 32) v = v & ((32'd1 << w) - 32'd1);
        return v;
    endfunction

    function automatic int half_len(int h, int w);
        case (h)
            0: return w + 2;
            1: return w;
            2: return w - 3;
            3: return w + 5;
            default: return w + 1;
        endcase
    endfunction

    function automatic int frame_len(int i, int w);
        case (i)
            0: return 8 * w + 3;
            1: return 8 * w - 1;
            2: return 8 * w;
            default: return 8 * w + 1;
        endcase
    endfunction

    task automatic push(input logic [31:0] d, input int c, input int k);
        exp_d[n_exp] = d;
        exp_c[n_exp] = c;
        exp_k[n_exp] = k;
        n_exp++;
    endtask

    task automatic build(input int f, input int wl);
        int w;
        int st[8];
        int ln[8];
        int nseg;
        int off;
        int prev;
        bit dsp;
        logic [31:0] word;
        w = wbits(wl);
        dsp = (f >= 3);
        n_s = 0;
        n_exp = 0;
        for (int k = 0; k < MAXS; k++) begin
            lr_s[k] = 1'b0; d_s[k] = 1'b0; e_s[k] = 1'b0;
        end
        for (int k = 0; k < 4; k++) begin
            lr_s[n_s] = 1'b0; d_s[n_s] = pad_bit(n_s, f, wl); n_s++;
        end
        nseg = dsp ? 4 : 5;
        for (int s = 0; s < nseg; s++) begin
            st[s] = n_s;
            ln[s] = dsp ? frame_len(s, w) : half_len(s, w);
            for (int p = 0; p < ln[s]; p++) begin
                lr_s[n_s] = dsp ? (p < ((s % 2 == 0) ? w : 1)) : (s % 2 == 0);
                d_s[n_s] = pad_bit(n_s, f, wl);
                n_s++;
            end
        end
        for (int t = 0; t < 6; t++) begin
            lr_s[n_s] = dsp ? 1'b0 : lr_s[n_s - 1];
            d_s[n_s] = pad_bit(n_s, f, wl);
            n_s++;
        end
        // word overlay and expected samples for the start-aligned formats
        for (int s = 0; s < nseg; s++) begin
            if (dsp) begin
                off = (f == 3) ? 0 : 1;
                for (int c = 0; c < 8; c++) begin
                    if (off + (c + 1) * w - 1 < ln[s] + off) begin
                        word = gen_word(s * 8 + c, f, wl, w);
                        for (int i = 0; i < w; i++) d_s[st[s] + off + c * w + i] = word[w - 1 - i];
                        push(word, c, st[s] + off + (c + 1) * w - 1);
                    end
                end
            end else if (ln[s] >= w) begin
                off = (f == 0) ? 0 : (f == 2) ? 1 : ln[s] - w;
                word = gen_word(s, f, wl, w);
                for (int i = 0; i < w; i++) d_s[st[s] + off + i] = word[w - 1 - i];
                if (f != 1) push(word, s % 2, st[s] + off + w - 1);
            end
        end
        // boundary scan: framing errors and right-justified deliveries
        prev = -1;
        for (int k = 1; k < n_s; k++) begin
            if (dsp ? (lr_s[k] && !lr_s[k - 1]) : (lr_s[k] != lr_s[k - 1])) begin
                if (prev >= 0) begin
                    e_s[k] = ((k - prev) < (dsp ? 8 * w : w));
                    if (f == 1) begin
                        word = '0;
                        for (int i = 0; i < w; i++) word[w - 1 - i] = d_s[k - w + i];
                        push(word, lr_s[k - 1] ? 0 : 1, k);
                    end
                end
                prev = k;
            end
        end
    endtask

    task automatic chk(input int k, input int f);
        checks++;
        if (frame_err !== e_s[k]) begin
            errors++;
            $display("FAIL %s frame_err after edge %0d: got %b exp %b",
                     (f >= 3) ? "R9" : "R8", k, frame_err, e_s[k]);
        end
        if (sample_valid === 1'b1) begin
            checks++;
            if (got >= n_exp) begin
                errors++;
                $display("FAIL R10 fmt %0d unexpected sample at edge %0d: got %h exp none",
                         f, k, sample_data);
            end else if (sample_data !== exp_d[got] || int'(sample_chan) != exp_c[got]
                         || k != exp_k[got]) begin
                errors++;
                $display("FAIL %s/R6/R7 sample %0d: got data %h chan %0d edge %0d exp data %h chan %0d edge %0d",
                         tag(f), got, sample_data, sample_chan, k, exp_d[got], exp_c[got], exp_k[got]);
            end
            got++;
        end else if (sample_valid !== 1'b0) begin
            checks++;
            errors++;
            $display("FAIL R7 sample_valid unknown at edge %0d: got %b exp 0/1", k, sample_valid);
        end
    endtask

    initial begin
        for (int f = 0; f < 5; f++) begin
            for (int wl = 0; wl < 4; wl++) begin
                rst_n = 1'b0;
                fmt = 3'(f);
                wlen = 2'(wl);
                lrclk = 1'b0;
                sdata = 1'b0;
                build(f, wl);
                got = 0;
                repeat (3) @(negedge bclk);
                checks++;
                if ({sample_valid, frame_err, sample_data, sample_chan} !== '0) begin
                    errors++;
                    $display("FAIL R11 reset outputs: got v%b e%b d%h c%0d exp all zero",
                             sample_valid, frame_err, sample_data, sample_chan);
                end
                rst_n = 1'b1;
                for (int k = 0; k < n_s; k++) begin
                    lrclk = lr_s[k];
                    sdata = d_s[k];
                    @(negedge bclk);
                    chk(k, f);
                end
                checks++;
                if (got != n_exp) begin
                    errors++;
                    $display("FAIL R10 fmt %0d wlen %0d sample count: got %0d exp %0d",
                             f, wl, got, n_exp);
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_800_000;
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule